// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block judges each incoming frame by its 48-bit destination address and tells the receive path whether to keep it. The address arrives one byte per accepted cycle, first byte first, with a start strobe on the first byte. While the bytes stream in, the block runs a byte-wide CRC-32. It then compares the complete address against a bank of exact-match station entries, a 64-bin multicast hash table and a set of override modes. It produces a keep/drop decision and a separate address-filter-fail flag.

Configuration is held in registers written through a plain write port. A mode word selects promiscuous operation, keep-everything debug operation, accept-all-multicast, hash-based multicast and broadcast rejection. Two 32-bit words form the hash table. A pair of words per entry describes each of the seventeen exact-match addresses: entry 0 is the station address and entries 1 to 16 are extra unicast addresses. Bytes that follow the sixth address byte belong to the rest of the frame and are ignored until the next start strobe.

Top module: `rxDestFilter`

## Requirements
- R1: The hash index is 6 bits. It is formed from the CRC-32 of the six address bytes, with these rules: the seed is all ones, each byte is fed least significant bit first, and the polynomial is 0x04C11DB7. Index bit 5 is the inverted CRC bit 31, down to index bit 0, which is the inverted CRC bit 26. Index bit 5 picks the upper hash word (register 2) over the lower one (register 1), and index bits 4..0 pick the bit in that word. With hash mode on (mode bit 3), a group address passes only when its hash bit is 1.
- R2: After reset, resultValid, frameAccept and daFilterFail are 0, every mode bit and hash bit is 0, and no exact-match entry is enabled.
- R3: Entry k (k = 0..16) takes its first four received bytes from register 4+2k, with the first byte in bits 7..0. Register 5+2k holds the last two bytes in bits 15..0 and the enable in bit 31. An enabled entry equal to the address makes the frame pass.
- R4: A non-broadcast address that no enabled entry matches, and that no multicast rule admits, gives frameAccept=0 and daFilterFail=1. Every valid result has at least one of the two outputs set.
- R5: The all-ones address passes unless broadcast rejection (mode bit 4) is set. When it is set, the all-ones address fails and is dropped.
- R6: With accept-all-multicast (mode bit 2), every non-broadcast address whose first byte has bit 0 set passes, whatever the hash table holds.
- R7: With promiscuous mode (mode bit 0), frameAccept=1 and daFilterFail=0 for every address.
- R8: With keep-everything mode (mode bit 1), frameAccept=1 for every address. daFilterFail still shows the filter outcome unless promiscuous mode is on.
- R9: resultValid, frameAccept and daFilterFail are updated at the clock edge that takes the sixth address byte. They then hold unchanged, including across later payload bytes, until the edge that takes the next start byte. That edge clears all three. Idle cycles between address bytes are allowed.
- R10: A group address that matches no enabled entry fails when neither hash mode nor accept-all-multicast is on.
- R11: A start strobe that arrives before six bytes are complete discards the partial address and begins a new one. No result is produced for the partial address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | REG_AW (6) | Register index: 0 mode, 1 hash low, 2 hash high, 4+2k / 5+2k entry k |
| regWrData | input | 32 | Register write data |
| byteValid | input | 1 | Byte on byteData is valid this cycle |
| byteSof | input | 1 | Valid byte is the first destination byte of a frame |
| byteData | input | 8 | Received byte |
| resultValid | output | 1 | Decision outputs are valid |
| frameAccept | output | 1 | Keep the frame |
| daFilterFail | output | 1 | The address did not pass the filter |

## Verification
Each result is due at the clock edge that takes the sixth address byte, so it can be read in the same cycle as the falling edge that follows. The start byte clears the outputs one edge after it is driven. The driver drives on falling edges and checks resultValid low on the falling edge after the start byte and high on the falling edge after the sixth byte. It then sends one payload byte and checks that both decision bits are unchanged one falling edge later. The monitor pops the expected decision at the falling edge where resultValid first reads high. The driver pushed that decision when it began the frame, so a result that is late, early or extra shows up as a mismatch or as an empty-queue pop.

// File: rtl/rxDestFilterPkg.sv
package rxDestFilterPkg;

  localparam int ADDR_BYTES = 6;
  localparam int ADDR_W     = 8 * ADDR_BYTES;
  localparam int WORD_W     = 32;
  localparam int HASH_W     = 2 * WORD_W;
  localparam int HASH_IDX_W = $clog2(HASH_W);
  localparam int MODE_REG   = 0;
  localparam int HASH_LO    = 1;
  localparam int HASH_HI    = 2;
  localparam int ENTRY_BASE = 4;
  localparam logic [WORD_W-1:0] CRC_POLY_REFL = 32'hEDB88320;

  typedef struct packed {
    logic bcastDisable;
    logic hashMcast;
    logic passAllMcast;
    logic recvAll;
    logic promisc;
  } modeCfg_t;

  typedef struct packed {
    logic takeByte;
    logic firstByte;
    logic lastByte;
  } byteStrobe_t;

  function automatic logic [WORD_W-1:0] crcStep(input logic [WORD_W-1:0] seed,
                                                input logic [7:0] data);
    logic [WORD_W-1:0] c;
    c = seed ^ {{(WORD_W-8){1'b0}}, data};
    for (int b = 0; b < 8; b++) begin
      c = c[0] ? ((c >> 1) ^ CRC_POLY_REFL) : (c >> 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/rxDestFilterRegs.sv
module rxDestFilterRegs
  import rxDestFilterPkg::*;
#(
  parameter int NUM_ENTRIES = 17,
  parameter int REG_AW      = 6
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic                                  regWrEn,
  input  logic [REG_AW-1:0]                     regAddr,
  input  logic [WORD_W-1:0]                     regWrData,
  output modeCfg_t                              modeCfg,
  output logic [HASH_W-1:0]                     hashTbl,
  output logic [NUM_ENTRIES-1:0][ADDR_W-1:0]    entryAddr,
  output logic [NUM_ENTRIES-1:0]                entryEn
);

  localparam int HI_PART_W = ADDR_W - WORD_W;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeCfg <= '0;
      hashTbl <= '0;
    end else if (regWrEn) begin
      if (regAddr == REG_AW'(MODE_REG)) modeCfg <= regWrData[$bits(modeCfg_t)-1:0];
      if (regAddr == REG_AW'(HASH_LO))  hashTbl[WORD_W-1:0] <= regWrData;
      if (regAddr == REG_AW'(HASH_HI))  hashTbl[HASH_W-1:WORD_W] <= regWrData;
    end
  end

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : gEntry
    localparam int LO_IDX = ENTRY_BASE + 2 * i;
    localparam int HI_IDX = LO_IDX + 1;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        entryAddr[i] <= '0;
        entryEn[i]   <= 1'b0;
      end else if (regWrEn) begin
        if (regAddr == REG_AW'(LO_IDX)) entryAddr[i][WORD_W-1:0] <= regWrData;
        if (regAddr == REG_AW'(HI_IDX)) begin
          entryAddr[i][ADDR_W-1:WORD_W] <= regWrData[HI_PART_W-1:0];
          entryEn[i]                    <= regWrData[WORD_W-1];
        end
      end
    end
  end

endmodule

// File: rtl/rxDestFilterCtrl.sv
module rxDestFilterCtrl
  import rxDestFilterPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        byteValid,
  input  logic        byteSof,
  output byteStrobe_t strobe,
  output logic        resultValid
);

  localparam int CNT_W = $clog2(ADDR_BYTES + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(ADDR_BYTES - 1);

  logic [CNT_W-1:0] byteCnt;
  logic             collecting;

  always_comb begin
    strobe.firstByte = byteValid && byteSof;
    strobe.takeByte  = byteValid && (byteSof || collecting);
    strobe.lastByte  = byteValid && !byteSof && collecting && (byteCnt == LAST_CNT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteCnt     <= '0;
      collecting  <= 1'b0;
      resultValid <= 1'b0;
    end else if (strobe.firstByte) begin
      byteCnt     <= CNT_W'(1);
      collecting  <= 1'b1;
      resultValid <= 1'b0;
    end else if (strobe.takeByte) begin
      byteCnt <= byteCnt + CNT_W'(1);
      if (strobe.lastByte) begin
        collecting  <= 1'b0;
        resultValid <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/rxDestFilterDatapath.sv
module rxDestFilterDatapath
  import rxDestFilterPkg::*;
#(
  parameter int NUM_ENTRIES = 17
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  byteStrobe_t                        strobe,
  input  logic [7:0]                         byteData,
  input  modeCfg_t                           modeCfg,
  input  logic [HASH_W-1:0]                  hashTbl,
  input  logic [NUM_ENTRIES-1:0][ADDR_W-1:0] entryAddr,
  input  logic [NUM_ENTRIES-1:0]             entryEn,
  output logic                               frameAccept,
  output logic                               daFilterFail
);

  logic [ADDR_W-9:0]       prevBytes;
  logic [WORD_W-1:0]       crcReg;
  logic [ADDR_W-1:0]       nextAddr;
  logic [WORD_W-1:0]       nextCrc;
  logic [HASH_IDX_W-1:0]   hashIdx;
  logic [WORD_W-1:0]       hashWord;
  logic                    hashHit;
  logic [NUM_ENTRIES-1:0]  matchVec;
  logic                    isBcast;
  logic                    isGroup;
  logic                    filterPass;

  assign nextAddr = {byteData, prevBytes};
  assign nextCrc  = crcStep(strobe.firstByte ? '1 : crcReg, byteData);

  always_comb begin
    for (int k = 0; k < HASH_IDX_W; k++) begin
      hashIdx[HASH_IDX_W-1-k] = ~nextCrc[k];
    end
  end

  assign hashWord = hashIdx[HASH_IDX_W-1] ? hashTbl[HASH_W-1:WORD_W] : hashTbl[WORD_W-1:0];
  assign hashHit  = hashWord[hashIdx[HASH_IDX_W-2:0]];

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : gMatch
    assign matchVec[i] = entryEn[i] && (entryAddr[i] == nextAddr);
  end

  assign isBcast = &nextAddr;
  assign isGroup = nextAddr[0];

  always_comb begin
    if (isBcast) begin
      filterPass = !modeCfg.bcastDisable;
    end else begin
      filterPass = (|matchVec) ||
                   (isGroup && (modeCfg.passAllMcast || (modeCfg.hashMcast && hashHit)));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevBytes <= '0;
      crcReg    <= '1;
    end else if (strobe.takeByte) begin
      prevBytes <= nextAddr[ADDR_W-1:8];
      crcReg    <= nextCrc;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.firstByte) begin
      frameAccept  <= 1'b0;
      daFilterFail <= 1'b0;
    end else if (strobe.lastByte) begin
      frameAccept  <= modeCfg.promisc || modeCfg.recvAll || filterPass;
      daFilterFail <= !modeCfg.promisc && !filterPass;
    end
  end

endmodule

// File: rtl/rxDestFilter.sv
module rxDestFilter
  import rxDestFilterPkg::*;
#(
  parameter  int NUM_EXTRA   = 16,
  localparam int NUM_ENTRIES = NUM_EXTRA + 1,
  localparam int REG_AW      = $clog2(ENTRY_BASE + 2 * NUM_ENTRIES)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [REG_AW-1:0]   regAddr,
  input  logic [WORD_W-1:0]   regWrData,
  input  logic                byteValid,
  input  logic                byteSof,
  input  logic [7:0]          byteData,
  output logic                resultValid,
  output logic                frameAccept,
  output logic                daFilterFail
);

  modeCfg_t                           modeCfg;
  logic [HASH_W-1:0]                  hashTbl;
  logic [NUM_ENTRIES-1:0][ADDR_W-1:0] entryAddr;
  logic [NUM_ENTRIES-1:0]             entryEn;
  byteStrobe_t                        strobe;

  rxDestFilterRegs #(.NUM_ENTRIES(NUM_ENTRIES), .REG_AW(REG_AW)) uRegs (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .modeCfg(modeCfg), .hashTbl(hashTbl), .entryAddr(entryAddr), .entryEn(entryEn)
  );

  rxDestFilterCtrl uCtrl (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteSof(byteSof),
    .strobe(strobe), .resultValid(resultValid)
  );

  rxDestFilterDatapath #(.NUM_ENTRIES(NUM_ENTRIES)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .byteData(byteData), .modeCfg(modeCfg),
    .hashTbl(hashTbl), .entryAddr(entryAddr), .entryEn(entryEn),
    .frameAccept(frameAccept), .daFilterFail(daFilterFail)
  );

endmodule

// File: rtl/rxDestFilterChk.sv
module rxDestFilterChk (
  input logic clk,
  input logic rstN,
  input logic byteValid,
  input logic byteSof,
  input logic resultValid,
  input logic frameAccept,
  input logic daFilterFail
);

  logic [2:0] seenCnt;
  logic       sixthSeen;

  assign sixthSeen = byteValid && !byteSof && (seenCnt == 3'd5);

  always_ff @(posedge clk) begin
    if (!rstN) seenCnt <= 3'd0;
    else if (byteValid && byteSof) seenCnt <= 3'd1;
    else if (byteValid && seenCnt != 3'd0 && seenCnt != 3'd6) seenCnt <= seenCnt + 3'd1;
  end

  p_quiet_until_result_r2: assert property (@(posedge clk) disable iff (!rstN)
    !resultValid |-> (!frameAccept && !daFilterFail));

  p_some_outcome_r4: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> (frameAccept || daFilterFail));

  p_sof_clears_r9: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && byteSof) |=> !resultValid);

  p_due_after_sixth_r9: assert property (@(posedge clk) disable iff (!rstN)
    sixthSeen |=> resultValid);

  p_rise_only_after_sixth_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resultValid) |-> $past(sixthSeen));

  p_held_r9: assert property (@(posedge clk) disable iff (!rstN)
    (resultValid && !(byteValid && byteSof)) |=>
      (resultValid && $stable(frameAccept) && $stable(daFilterFail)));

endmodule

bind rxDestFilter rxDestFilterChk uChk (
  .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteSof(byteSof),
  .resultValid(resultValid), .frameAccept(frameAccept), .daFilterFail(daFilterFail)
);

// File: tb/sim_rxDestFilter.sv
module sim_rxDestFilter;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_ENT    = 17;
  localparam int REG_AW     = 6;

  logic clk, rstN, regWrEn, byteValid, byteSof;
  logic [REG_AW-1:0] regAddr;
  logic [31:0] regWrData;
  logic [7:0]  byteData;
  logic resultValid, frameAccept, daFilterFail;

  rxDestFilter u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .byteValid(byteValid), .byteSof(byteSof), .byteData(byteData),
    .resultValid(resultValid), .frameAccept(frameAccept), .daFilterFail(daFilterFail)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  logic [4:0]  shMode;
  logic [63:0] shHash;
  logic [47:0] shAddr [NUM_ENT];
  logic        shEn   [NUM_ENT];

  logic [1:0] expQ[$];
  string      tagQ[$];

  task automatic check(input string req, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [5:0] hashIndex(input logic [47:0] a);
    logic [31:0] c;
    logic fb;
    c = 32'hFFFFFFFF;
    for (int i = 0; i < 6; i++) begin
      for (int j = 0; j < 8; j++) begin
        fb = c[31] ^ a[8*i+j];
        c = c << 1;
        if (fb) c = c ^ 32'h04C11DB7;
      end
    end
    c = ~c;
    return c[31:26];
  endfunction

  function automatic logic [1:0] model(input logic [47:0] a);
    logic perfect, pass, bc, grp, hit;
    perfect = 1'b0;
    for (int k = 0; k < NUM_ENT; k++) if (shEn[k] && shAddr[k] == a) perfect = 1'b1;
    bc  = (a == 48'hFFFF_FFFF_FFFF);
    grp = a[0];
    hit = shHash[hashIndex(a)];
    if (bc) pass = !shMode[4];
    else    pass = perfect || (grp && (shMode[2] || (shMode[3] && hit)));
    return {shMode[0] || shMode[1] || pass, !shMode[0] && !pass};
  endfunction

  task automatic writeReg(input int a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = REG_AW'(a); regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic setMode(input logic [4:0] m);
    writeReg(0, {27'b0, m}); shMode = m;
  endtask

  task automatic setHash(input logic [63:0] h);
    writeReg(1, h[31:0]); writeReg(2, h[63:32]); shHash = h;
  endtask

  task automatic setEntry(input int k, input logic [47:0] a, input logic en);
    writeReg(4 + 2 * k, a[31:0]);
    writeReg(5 + 2 * k, {en, 15'b0, a[47:32]});
    shAddr[k] = a; shEn[k] = en;
  endtask

  // Driver: pushes the expected decision, then streams the address.
  task automatic sendFrame(input logic [47:0] a, input bit gap, input string tag);
    logic accHeld, failHeld;
    expQ.push_back(model(a));
    tagQ.push_back(tag);
    for (int i = 0; i < 6; i++) begin
      if (i > 0 && gap) begin
        @(negedge clk); byteValid = 1'b0;
      end
      @(negedge clk);
      if (i == 1) check("R9", "valid cleared after start byte", resultValid, 0);
      byteValid = 1'b1; byteSof = (i == 0); byteData = a[8*i +: 8];
    end
    @(negedge clk);
    byteValid = 1'b0; byteSof = 1'b0;
    check("R9", "valid after sixth byte", resultValid, 1);
    accHeld = frameAccept; failHeld = daFilterFail;
    byteValid = 1'b1; byteData = 8'hA5;
    @(negedge clk);
    byteValid = 1'b0;
    check("R9", "held across payload", {resultValid, frameAccept, daFilterFail},
          {1'b1, accHeld, failHeld});
  endtask

  // Monitor: compares each new result against the scoreboard.
  initial begin
    logic prevValid;
    logic [1:0] e;
    string t;
    prevValid = 1'b0;
    forever begin
      @(negedge clk);
      if (rstN && resultValid && !prevValid) begin
        if (expQ.size() == 0) begin
          check("R11", "unexpected result", 1, 0);
        end else begin
          e = expQ.pop_front();
          t = tagQ.pop_front();
          check(t, "decision {accept,fail}", {frameAccept, daFilterFail}, e);
        end
      end
      prevValid = resultValid;
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    logic [47:0] mcHi, mcLo, cand, station, extra;
    bit gotHi, gotLo;
    rstN = 1'b0; regWrEn = 1'b0; regAddr = '0; regWrData = '0;
    byteValid = 1'b0; byteSof = 1'b0; byteData = '0;
    shMode = '0; shHash = '0;
    for (int k = 0; k < NUM_ENT; k++) begin shAddr[k] = '0; shEn[k] = 1'b0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R2", "outputs after reset", {resultValid, frameAccept, daFilterFail}, 3'b000);

    station = 48'h665544_332210;
    extra   = 48'h0F0E0D_0C0B0A;
    // R2: no entry enabled, so an ordinary unicast fails (R4 too)
    sendFrame(station, 0, "R2");
    check("R4", "unmatched unicast", {frameAccept, daFilterFail}, 2'b01);

    // R3: station entry and the last extra entry
    setEntry(0, station, 1'b1);
    setEntry(16, extra, 1'b1);
    sendFrame(station, 0, "R3");
    check("R3", "station match", {frameAccept, daFilterFail}, 2'b10);
    sendFrame(extra, 1, "R3");
    setEntry(5, 48'h123456_789ABC, 1'b0);
    sendFrame(48'h123456_789ABC, 0, "R4");
    check("R4", "disabled entry ignored", {frameAccept, daFilterFail}, 2'b01);

    // R5: broadcast
    sendFrame(48'hFFFF_FFFF_FFFF, 0, "R5");
    check("R5", "broadcast kept", {frameAccept, daFilterFail}, 2'b10);
    setMode(5'b10000);
    sendFrame(48'hFFFF_FFFF_FFFF, 0, "R5");
    check("R5", "broadcast rejected", {frameAccept, daFilterFail}, 2'b01);
    setMode(5'b00000);

    // find group addresses landing in each hash word
    gotHi = 0; gotLo = 0; mcHi = '0; mcLo = '0;
    for (int c = 0; c < 256; c++) begin
      cand = {8'(c), 32'h2233_4455, 8'h01};
      if (hashIndex(cand) >= 6'd32 && !gotHi) begin mcHi = cand; gotHi = 1; end
      if (hashIndex(cand) <  6'd32 && !gotLo) begin mcLo = cand; gotLo = 1; end
    end

    // R10: group address without hash or pass-all
    setHash(64'hFFFF_FFFF_FFFF_FFFF);
    sendFrame(mcHi, 0, "R10");
    check("R10", "multicast with hash off", {frameAccept, daFilterFail}, 2'b01);

    // R1: hash mode, single bins in each word
    setMode(5'b01000);
    setHash(64'd1 << hashIndex(mcHi));
    sendFrame(mcHi, 0, "R1");
    check("R1", "high word bin hit", {frameAccept, daFilterFail}, 2'b10);
    sendFrame(mcLo, 0, "R1");
    setHash(64'd1 << hashIndex(mcLo));
    sendFrame(mcLo, 1, "R1");
    check("R1", "low word bin hit", {frameAccept, daFilterFail}, 2'b10);
    setHash(~(64'd1 << hashIndex(mcLo)));
    sendFrame(mcLo, 0, "R1");
    check("R1", "bin cleared", {frameAccept, daFilterFail}, 2'b01);

    // R6: pass-all multicast
    setHash(64'd0);
    setMode(5'b00100);
    sendFrame(mcHi, 0, "R6");
    sendFrame({24'hABCDEF, 24'h000003}, 0, "R6");
    sendFrame(48'h000000_000002, 0, "R6");
    check("R6", "unicast still filtered", {frameAccept, daFilterFail}, 2'b01);

    // R8: keep-everything
    setMode(5'b00010);
    sendFrame(48'h000000_000002, 0, "R8");
    check("R8", "kept but flagged", {frameAccept, daFilterFail}, 2'b11);
    sendFrame(station, 0, "R8");

    // R7: promiscuous
    setMode(5'b10011);
    sendFrame(48'h000000_000002, 0, "R7");
    check("R7", "promiscuous", {frameAccept, daFilterFail}, 2'b10);
    sendFrame(48'hFFFF_FFFF_FFFF, 1, "R7");
    setMode(5'b00000);

    // R11: partial address restarted by a new start byte
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      byteValid = 1'b1; byteSof = (i == 0); byteData = 8'h10 + 8'(i);
    end
    @(negedge clk);
    byteValid = 1'b0; byteSof = 1'b0;
    check("R11", "no result for partial address", resultValid, 0);
    sendFrame(extra, 0, "R11");

    repeat (3) @(negedge clk);
    check("R11", "scoreboard drained", expQ.size(), 0);
    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule